// File: doc/BRIEF.md
# Write-completion ACK polling sequencer

This block is the master-side sequencer that sits above a byte-level I2C engine. It is used after a write to a serial EEPROM. The sequencer detects when the device has finished its internal programming cycle by polling for an acknowledge. It then moves straight into the next queued operation. Each poll attempt is a START condition followed by the device-select byte with the R/W bit at 0. While the device is busy it does not acknowledge that byte, and the sequencer tries again. When the byte is acknowledged, the sequencer keeps it as the first byte of the next instruction, so no extra frame is spent.

A command carries three things: the kind of the next operation, a 13-bit byte address and a poll enable. The per-command retry limit is latched together with the command. The next operation is one of three kinds:
- No memory access: the sequencer closes the bus with a STOP.
- Write: the sequencer sends the two address bytes and hands the held bus to the data phase.
- Random read: the sequencer sends the two address bytes, issues a repeated START and sends the device-select byte with R/W at 1, then hands over.

A device that never answers ends the command with a timeout status once the retry limit is spent.

Top module: `acp_poll_seq`

## Requirements
- R1: A command is taken only when `cmd_valid` is high while `busy` is low. `busy` rises on the next cycle and stays high until the cycle of `done`. A command offered while `busy` is high is ignored.
- R2: Each poll attempt is one engine request with `eng_op`=0 (START), followed by one request with `eng_op`=3 (send byte) carrying `{DEV_ADDR,1'b0}` (0xA0 by default).
- R3: A poll device-select that returns NACK (`eng_ack`=0) is followed by a fresh START and device-select, provided attempts remain.
- R4: With polling enabled, the number of attempts is limited to `max_tries`, where 0 counts as 1. If every attempt is NACKed, the sequencer requests a STOP (`eng_op`=2) and ends with `status`=1 (timeout).
- R5: With `cmd_poll`=0, exactly one attempt is made, whatever the value of `max_tries`.
- R6: When the device-select is acknowledged and `cmd_op`=0 (no memory access; 3 behaves the same), the sequencer requests a STOP and then ends with `status`=0.
- R7: When the device-select is acknowledged and `cmd_op`=1 (write), the sequencer sends `{3'b000,addr[12:8]}` and then `addr[7:0]`. It then ends with `status`=0 and issues no STOP.
- R8: When the device-select is acknowledged and `cmd_op`=2 (random read), the sequencer sends the two address bytes as in R7. It then requests a repeated START (`eng_op`=1) with no STOP before it, sends `{DEV_ADDR,1'b1}`, and ends with `status`=0.
- R9: A NACK on an address byte, or on the read device-select, leads to a STOP request and then to `status`=2.
- R10: At most one engine request is outstanding. `eng_req` is a one-cycle pulse, and it is not raised again until `eng_done` has returned.
- R11: `done` is a one-cycle pulse, high in the same cycle that `busy` falls. `status` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offer |
| cmd_op | input | 2 | Next operation: 0 none, 1 write, 2 random read |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_poll | input | 1 | 1 = poll until ready, 0 = single attempt |
| max_tries | input | TRY_W | Attempt limit while polling (0 treated as 1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 NACK after ready |
| eng_req | output | 1 | Request pulse to byte engine |
| eng_op | output | 2 | 0 START, 1 repeated START, 2 STOP, 3 send byte |
| eng_byte | output | 8 | Byte to send with op 3 |
| eng_done | input | 1 | Engine finished the request |
| eng_ack | input | 1 | Acknowledge seen for a sent byte |

## Verification
A wrong internal state shows up at the ports in one of two ways. The engine request stream may diverge from the expected frame sequence at the very next request: a missing START, a wrong R/W bit, a STOP where a restart belongs, or an extra attempt beyond the limit. Alternatively, the `status` value on the `done` pulse may be wrong. A miscounted retry counter surfaces only at the end of polling, as one attempt too many or too few. Each bug is therefore exposed within one engine round trip, or by the attempt count once the limit is reached.

// File: rtl/acp_pkg.sv
// Package: shared encodings for the ACK polling sequencer.
// Assumes the byte engine decodes eng_op with the values below.
package acp_pkg;

    typedef enum logic [1:0] {
        ENG_START   = 2'd0,
        ENG_RESTART = 2'd1,
        ENG_STOP    = 2'd2,
        ENG_SEND    = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        NXT_NONE  = 2'd0,
        NXT_WRITE = 2'd1,
        NXT_READ  = 2'd2,
        NXT_RSVD  = 2'd3
    } nxt_op_e;

    typedef enum logic [1:0] {
        STS_OK      = 2'd0,
        STS_TIMEOUT = 2'd1,
        STS_NACK    = 2'd2
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_START,
        S_POLL_DSEL,
        S_ADDR_HI,
        S_ADDR_LO,
        S_RESTART,
        S_RD_DSEL,
        S_STOP
    } state_e;

endpackage

// File: rtl/acp_try_ctr.sv
// Module: attempt counter for ACK polling.
// Counts NACKed poll attempts since the last clear and flags when the
// current attempt is the last one allowed. Assumes limit and poll_en are
// held stable for the whole command.
module acp_try_ctr #(
    parameter int TRY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [TRY_W-1:0] limit,
    input  logic             poll_en,
    output logic             last_try
);

    localparam logic [TRY_W:0] ONE = {{TRY_W{1'b0}}, 1'b1};

    logic [TRY_W:0] cnt_q;
    logic [TRY_W:0] eff_lim;

    // Attempt count register: cleared per command, advanced on each retry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Effective limit: one attempt when polling is off or the limit is zero.
    always_comb begin
        if (!poll_en || (limit == '0)) begin
            eff_lim = ONE;
        end else begin
            eff_lim = {1'b0, limit};
        end
    end

    assign last_try = (cnt_q + ONE) >= eff_lim;

endmodule

// File: rtl/acp_frame.sv
// Module: frame builder.
// Maps the sequencer state to the engine operation and the byte to send.
// Assumes ADDR_W lies between 9 and 16, so that the address fits two bytes.
module acp_frame
    import acp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 13
) (
    input  state_e            state,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_byte
);

    localparam int PAD_W = 16;

    logic [PAD_W-1:0] addr_pad;

    // Zero-extend the address so that the unused high bits go out as zero.
    assign addr_pad = PAD_W'(addr);

    // Operation and byte selection for each request state.
    always_comb begin
        eng_op   = ENG_SEND;
        eng_byte = 8'h00;
        unique case (state)
            S_POLL_START: eng_op = ENG_START;
            S_POLL_DSEL:  eng_byte = {DEV_ADDR, 1'b0};
            S_ADDR_HI:    eng_byte = addr_pad[15:8];
            S_ADDR_LO:    eng_byte = addr_pad[7:0];
            S_RESTART:    eng_op = ENG_RESTART;
            S_RD_DSEL:    eng_byte = {DEV_ADDR, 1'b1};
            S_STOP:       eng_op = ENG_STOP;
            default:      eng_op = ENG_SEND;
        endcase
    end

endmodule

// File: rtl/acp_fsm.sv
// Module: sequencing state machine.
// Issues one engine request per state and waits for eng_done before it
// moves on. Assumes the engine answers every request exactly once, with a
// single-cycle eng_done.
module acp_fsm
    import acp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_accept,
    input  nxt_op_e    nxt_op,
    input  logic       eng_done,
    input  logic       eng_ack,
    input  logic       last_try,
    output state_e     state,
    output logic       eng_req,
    output logic       try_clr,
    output logic       try_inc,
    output logic       busy,
    output logic       done,
    output logic [1:0] status
);

    state_e  state_q, state_d;
    logic    pend_q;
    status_e stop_st_q, stop_st_d;
    logic    fin;
    status_e fin_st;
    logic    ev;
    logic    mem_op;
    logic    done_q;
    status_e status_q;

    assign ev     = pend_q && eng_done;
    assign mem_op = (nxt_op == NXT_WRITE) || (nxt_op == NXT_READ);

    // Next-state, retry and completion decode.
    always_comb begin
        state_d   = state_q;
        stop_st_d = stop_st_q;
        fin       = 1'b0;
        fin_st    = STS_OK;
        try_inc   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_accept) state_d = S_POLL_START;
            end
            S_POLL_START: begin
                if (ev) state_d = S_POLL_DSEL;
            end
            S_POLL_DSEL: begin
                if (ev) begin
                    if (eng_ack) begin
                        state_d   = mem_op ? S_ADDR_HI : S_STOP;
                        stop_st_d = STS_OK;
                    end else if (last_try) begin
                        state_d   = S_STOP;
                        stop_st_d = STS_TIMEOUT;
                    end else begin
                        state_d = S_POLL_START;
                        try_inc = 1'b1;
                    end
                end
            end
            S_ADDR_HI: begin
                if (ev) begin
                    if (eng_ack) begin
                        state_d = S_ADDR_LO;
                    end else begin
                        state_d   = S_STOP;
                        stop_st_d = STS_NACK;
                    end
                end
            end
            S_ADDR_LO: begin
                if (ev) begin
                    if (!eng_ack) begin
                        state_d   = S_STOP;
                        stop_st_d = STS_NACK;
                    end else if (nxt_op == NXT_READ) begin
                        state_d = S_RESTART;
                    end else begin
                        state_d = S_IDLE;
                        fin     = 1'b1;
                    end
                end
            end
            S_RESTART: begin
                if (ev) state_d = S_RD_DSEL;
            end
            S_RD_DSEL: begin
                if (ev) begin
                    if (eng_ack) begin
                        state_d = S_IDLE;
                        fin     = 1'b1;
                    end else begin
                        state_d   = S_STOP;
                        stop_st_d = STS_NACK;
                    end
                end
            end
            S_STOP: begin
                if (ev) begin
                    state_d = S_IDLE;
                    fin     = 1'b1;
                    fin_st  = stop_st_q;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State, outstanding-request flag and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            pend_q    <= 1'b0;
            stop_st_q <= STS_OK;
            done_q    <= 1'b0;
            status_q  <= STS_OK;
        end else begin
            state_q   <= state_d;
            stop_st_q <= stop_st_d;
            done_q    <= fin;
            if (fin) status_q <= fin_st;
            if (eng_req) begin
                pend_q <= 1'b1;
            end else if (ev) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign eng_req = (state_q != S_IDLE) && !pend_q;
    assign try_clr = cmd_accept;
    assign busy    = state_q != S_IDLE;
    assign done    = done_q;
    assign status  = status_q;
    assign state   = state_q;

endmodule

// File: rtl/acp_poll_seq.sv
// Module: top level of the write-completion ACK polling sequencer.
// Latches one command, polls the device-select byte until it is
// acknowledged, then runs the address phase of the next operation.
// Assumes a byte engine that performs start, restart, stop and byte-send
// requests and reports the acknowledge of each sent byte.
module acp_poll_seq
    import acp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 13,
    parameter int         TRY_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_poll,
    input  logic [TRY_W-1:0]  max_tries,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_byte,
    input  logic              eng_done,
    input  logic              eng_ack
);

    logic              cmd_accept;
    nxt_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              poll_q;
    logic [TRY_W-1:0]  lim_q;
    state_e            state;
    logic              try_clr;
    logic              try_inc;
    logic              last_try;

    assign cmd_accept = cmd_valid && !busy;

    // Command capture on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= NXT_NONE;
            addr_q <= '0;
            poll_q <= 1'b0;
            lim_q  <= '0;
        end else if (cmd_accept) begin
            op_q   <= nxt_op_e'(cmd_op);
            addr_q <= cmd_addr;
            poll_q <= cmd_poll;
            lim_q  <= max_tries;
        end
    end

    acp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (cmd_accept),
        .nxt_op     (op_q),
        .eng_done   (eng_done),
        .eng_ack    (eng_ack),
        .last_try   (last_try),
        .state      (state),
        .eng_req    (eng_req),
        .try_clr    (try_clr),
        .try_inc    (try_inc),
        .busy       (busy),
        .done       (done),
        .status     (status)
    );

    acp_try_ctr #(.TRY_W(TRY_W)) u_try (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (try_clr),
        .inc      (try_inc),
        .limit    (lim_q),
        .poll_en  (poll_q),
        .last_try (last_try)
    );

    acp_frame #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_frame (
        .state    (state),
        .addr     (addr_q),
        .eng_op   (eng_op),
        .eng_byte (eng_byte)
    );

endmodule

// File: rtl/acp_poll_seq_chk.sv
// Module: protocol checker for acp_poll_seq, bound to every instance.
// Tracks outstanding requests and the last requested operation from the
// ports alone.
module acp_poll_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       eng_req,
    input logic [1:0] eng_op,
    input logic       eng_done
);

    logic       outst_q;
    logic [1:0] last_op_q;

    // Outstanding request and last requested operation, seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q   <= 1'b0;
            last_op_q <= 2'd0;
        end else begin
            if (eng_req) begin
                outst_q   <= 1'b1;
                last_op_q <= eng_op;
            end else if (eng_done) begin
                outst_q <= 1'b0;
            end
        end
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !outst_q);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r4_timeout_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> (last_op_q == 2'd2));

    a_r9_nack_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> (last_op_q == 2'd2));

endmodule

bind acp_poll_seq acp_poll_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_done  (eng_done)
);

// File: tb/acp_poll_seq_bench.sv
// Bench: vector table of commands and device responses, followed by
// directed tests for reset and for a command offered while busy.
module acp_poll_seq_bench;

    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;
    localparam int NV = 12;

    typedef struct packed {
        logic [1:0]  op;
        logic [12:0] addr;
        logic        poll;
        logic [7:0]  tries;
        logic [7:0]  nacks;
        logic        anack;
        logic [1:0]  est;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 13'h0000, 1'b1, 8'd10,  8'd0,   1'b0, 2'd0}, // R6 ready at once
        '{2'd1, 13'h1ABC, 1'b1, 8'd10,  8'd3,   1'b0, 2'd0}, // R3 R7
        '{2'd2, 13'h0123, 1'b1, 8'd10,  8'd2,   1'b0, 2'd0}, // R8
        '{2'd1, 13'h1FFF, 1'b1, 8'd4,   8'd4,   1'b0, 2'd1}, // R4
        '{2'd1, 13'h0005, 1'b0, 8'd10,  8'd1,   1'b0, 2'd1}, // R5 single try
        '{2'd1, 13'h0A07, 1'b0, 8'd10,  8'd0,   1'b0, 2'd0}, // R5 R7
        '{2'd2, 13'h1000, 1'b1, 8'd5,   8'd0,   1'b1, 2'd2}, // R9
        '{2'd0, 13'h0000, 1'b1, 8'd0,   8'd1,   1'b0, 2'd1}, // R4 zero limit
        '{2'd0, 13'h0042, 1'b1, 8'd3,   8'd2,   1'b0, 2'd0}, // R4 last try acked
        '{2'd1, 13'h1234, 1'b1, 8'd255, 8'd255, 1'b0, 2'd1}, // R4 max limit
        '{2'd1, 13'h00FF, 1'b1, 8'd255, 8'd254, 1'b0, 2'd0}, // R3 long poll
        '{2'd1, 13'h0ABC, 1'b1, 8'd6,   8'd0,   1'b1, 2'd2}  // R9 write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [12:0] cmd_addr = '0;
    logic        cmd_poll = 1'b0;
    logic [7:0]  max_tries = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [7:0]  eng_byte;
    logic        eng_done = 1'b0;
    logic        eng_ack = 1'b0;

    // Engine model configuration and log.
    logic        tb_clr = 1'b0;
    int          cfg_nacks = 0;
    logic        cfg_anack = 1'b0;
    logic [9:0]  log_q [1024];
    int          log_n = 0;
    int          polls = 0;
    int          addr_idx = 0;
    int          lat = 0;
    logic        pend_ack = 1'b0;
    logic        after_start = 1'b0;

    logic [9:0]  exp_q [1024];
    int          exp_n;
    int          n_chk = 0;
    int          n_fail = 0;
    int          n_done = 0;

    always #10 clk = ~clk;

    acp_poll_seq u_acp_poll_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_poll  (cmd_poll),
        .max_tries (max_tries),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .eng_req   (eng_req),
        .eng_op    (eng_op),
        .eng_byte  (eng_byte),
        .eng_done  (eng_done),
        .eng_ack   (eng_ack)
    );

    // Byte engine model: logs each request and answers two cycles later.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (done) n_done <= n_done + 1;
        if (tb_clr) begin
            log_n       <= 0;
            polls       <= 0;
            addr_idx    <= 0;
            lat         <= 0;
            after_start <= 1'b0;
            n_done      <= 0;
        end else begin
            if (lat != 0) begin
                lat <= lat - 1;
                if (lat == 1) begin
                    eng_done <= 1'b1;
                    eng_ack  <= pend_ack;
                end
            end
            if (eng_req) begin
                log_q[log_n] <= {eng_op, (eng_op == 2'd3) ? eng_byte : 8'h00};
                log_n <= log_n + 1;
                lat   <= 2;
                pend_ack <= 1'b1;
                after_start <= (eng_op == 2'd0) || (eng_op == 2'd1);
                if (eng_op == 2'd3) begin
                    if (after_start && eng_byte == DEVW) begin
                        pend_ack <= (polls >= cfg_nacks);
                        polls <= polls + 1;
                    end else if (after_start && eng_byte == DEVR) begin
                        pend_ack <= 1'b1;
                    end else begin
                        pend_ack <= !(addr_idx == 0 && cfg_anack);
                        addr_idx <= addr_idx + 1;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired: actual hang, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_chk = n_chk + 1;
        if (act != expv) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Expected request stream from the requirements.
    task automatic build_exp(input vec_t v);
        int lim, att;
        exp_n = 0;
        lim = v.poll ? ((v.tries == 0) ? 1 : int'(v.tries)) : 1;
        att = (int'(v.nacks) >= lim) ? lim : int'(v.nacks) + 1;
        for (int i = 0; i < att; i++) begin
            exp_q[exp_n] = {2'd0, 8'h00}; exp_n++;
            exp_q[exp_n] = {2'd3, DEVW};  exp_n++;
        end
        if (int'(v.nacks) >= lim) begin
            exp_q[exp_n] = {2'd2, 8'h00}; exp_n++;
        end else if (v.op == 2'd1 || v.op == 2'd2) begin
            exp_q[exp_n] = {2'd3, 3'b000, v.addr[12:8]}; exp_n++;
            if (v.anack) begin
                exp_q[exp_n] = {2'd2, 8'h00}; exp_n++;
            end else begin
                exp_q[exp_n] = {2'd3, v.addr[7:0]}; exp_n++;
                if (v.op == 2'd2) begin
                    exp_q[exp_n] = {2'd1, 8'h00}; exp_n++;
                    exp_q[exp_n] = {2'd3, DEVR};  exp_n++;
                end
            end
        end else begin
            exp_q[exp_n] = {2'd2, 8'h00}; exp_n++;
        end
    endtask

    function automatic int seq_mismatch();
        for (int i = 0; i < exp_n; i++) begin
            if (log_q[i] !== exp_q[i]) return i + 1;
        end
        return 0;
    endfunction

    task automatic clear_model(input vec_t v);
        @(negedge clk);
        cfg_nacks = int'(v.nacks);
        cfg_anack = v.anack;
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    task automatic issue(input vec_t v);
        cmd_valid = 1'b1;
        cmd_op    = v.op;
        cmd_addr  = v.addr;
        cmd_poll  = v.poll;
        max_tries = v.tries;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic score(input vec_t v, input string tag);
        int mm;
        build_exp(v);
        check(tag, int'(status), int'(v.est), "status on done (R11)");
        check(tag, log_n, exp_n, "request count (R2 R3 R10)");
        mm = seq_mismatch();
        if (mm != 0) begin
            check(tag, int'(log_q[mm-1]), int'(exp_q[mm-1]), "request stream entry");
        end else begin
            check(tag, 0, 0, "request stream");
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.est == 2'd1) return v.poll ? "R4" : "R5";
        if (v.est == 2'd2) return "R9";
        if (v.op == 2'd1) return "R7";
        if (v.op == 2'd2) return "R8";
        return "R6";
    endfunction

    initial begin
        vec_t vb;
        // Reset state.
        repeat (3) @(negedge clk);
        check("R1", int'(busy), 0, "busy in reset");
        check("R11", int'(done), 0, "done in reset");
        check("R10", int'(eng_req), 0, "eng_req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(busy), 0, "busy after reset");

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            clear_model(VECS[k]);
            issue(VECS[k]);
            check("R1", int'(busy), 1, "busy after accept");
            wait_done();
            check("R11", int'(busy), 0, "busy low with done");
            score(VECS[k], tag_of(VECS[k]));
            @(negedge clk);
            check("R11", int'(done), 0, "done single cycle");
        end

        // Directed: command offered while busy is ignored (R1).
        vb = '{2'd1, 13'h0ABC, 1'b1, 8'd6, 8'd2, 1'b0, 2'd0};
        clear_model(vb);
        issue(vb);
        repeat (5) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'd2;
        cmd_addr  = 13'h1111;
        cmd_poll  = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        score(vb, "R1");
        repeat (10) @(negedge clk);
        check("R1", int'(busy), 0, "no busy from ignored command");
        check("R1", n_done, 1, "done pulses for one command");
        check("R1", log_n, exp_n, "no requests from ignored command");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule